// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside the instruction cache in the fetch path. When fetch is redirected to a branch target, the target address is presented as a lookup. On a hit, the block returns the first two instructions stored for that target in the next cycle, one cycle before the instruction cache could supply them. On a miss, the instruction cache supplies the target instructions instead. Once those instructions are fetched, they are written into the block as a fill, so that the next redirect to the same target hits. The instructions after the cached pair always come from the instruction cache, starting in the cycle after the hit.

The block has 16 sets of 4 ways, 64 entries in all. The set index is address bits [5:2] and the tag is the address bits above bit 5. Each set keeps a 3-bit pseudo-LRU tree. A fill uses an invalid way when the set has one and otherwise replaces the way the tree selects. A target in the last word of an aligned fetch block has only one useful instruction, so its entry holds a single instruction. A flush input empties the whole structure in one cycle.

The lookup and fill inputs each use a valid/ready pair. Both ready outputs are high except while `flush` is high. A request is accepted in a cycle where its valid and ready are both high. The response has no back-pressure: the fetch queue must take `rsp_valid` in the cycle it appears.

Top module: `btic_top`

## Requirements
- R1: After reset, `rsp_valid` is low while no lookup is made, both ready outputs are high, and every lookup misses.
- R2: `rsp_valid` is high in exactly the cycles that follow an accepted lookup. `rsp_hit` and `rsp_pair` are never high without `rsp_valid`.
- R3: A lookup that hits returns the instructions written by the most recent fill of that address: `rsp_insn0` holds the first instruction and `rsp_insn1` the second.
- R4: The set index is address bits [5:2] and the tag is address bits [31:6]. All 64 entries (4 distinct tags in each of the 16 sets) can be resident at once, and a tag that was never filled misses.
- R5: A fill into a set that still has an invalid way never evicts a valid entry.
- R6: A fill into a full set replaces the pseudo-LRU victim. The tree bits are b0, b1 and b2. The victim is way (b1 ? 1 : 0) when b0 = 0, and way (b2 ? 3 : 2) when b0 = 1. Using way 0 or 1 sets b0 = 1 and sets b1 = 1 for way 0 or b1 = 0 for way 1. Using way 2 or 3 sets b0 = 0 and sets b2 = 1 for way 2 or b2 = 0 for way 3. Reset and flush clear all tree bits to zero.
- R7: A lookup hit counts as a use of that way in the replacement tree, in the same way as a fill does.
- R8: A fill to an address that is already resident overwrites that entry in place and does not allocate a second way.
- R9: A target whose word offset within an 8-word fetch block (address bits [4:2]) is 7 is stored with only its first instruction. A hit on such a target returns `rsp_pair` = 0. A hit on any other target returns `rsp_pair` = 1.
- R10: While `flush` is high, `lk_ready` and `fill_ready` are low. After a flush, every lookup misses.
- R11: A lookup and a fill accepted in the same cycle: the lookup sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries and clear replacement state |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 32 | Branch target address to look up |
| rsp_valid | output | 1 | Response for the lookup accepted in the previous cycle |
| rsp_hit | output | 1 | Target found |
| rsp_pair | output | 1 | Second instruction slot is valid |
| rsp_insn0 | output | 32 | First instruction at the target |
| rsp_insn1 | output | 32 | Second instruction at the target |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted |
| fill_addr | input | 32 | Target address being filled |
| fill_insn0 | input | 32 | First instruction at the target |
| fill_insn1 | input | 32 | Second instruction (ignored for the last word of a block) |

## Verification
The assertions assume that `rst_n` is released away from a clock edge. They also assume that an upstream stage reads `rsp_valid` in every cycle, because the response cannot stall. The bench meets both conditions by changing every input on the falling clock edge. It offers lookups and fills only through the valid/ready handshake, so no request is made while `flush` holds the ready outputs low. The addresses used in the sweeps place four tags in every set, and the word offset follows the set index, so every set and both single-instruction and pair entries are covered.

// File: rtl/btic_pkg.sv
package btic_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;
  localparam int TREE_W   = 3;

  typedef logic [TREE_W-1:0] tree_t;
  typedef logic [WAY_W-1:0]  way_t;

  // victim selection: root bit chooses the half, leaf bit chooses the way
  function automatic way_t tree_victim(input tree_t t);
    if (!t[0]) return t[1] ? way_t'(1) : way_t'(0);
    else       return t[2] ? way_t'(3) : way_t'(2);
  endfunction

  // record a use of way w: point the root and the leaf away from it
  function automatic tree_t tree_touch(input tree_t t, input way_t w);
    tree_t n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic way_t onehot_to_way(input logic [NUM_WAYS-1:0] oh);
    way_t r = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (oh[i]) r = r | way_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/btic_plru.sv
module btic_plru
  import btic_pkg::*;
#(
  parameter int SETS  = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lt_en,
  input  logic [IDX_W-1:0] lt_idx,
  input  way_t             lt_way,
  input  logic             ft_en,
  input  logic [IDX_W-1:0] ft_idx,
  input  way_t             ft_way,
  output way_t             victim
);
  tree_t st_q [SETS];
  tree_t ft_base;
  logic  same_set;

  assign same_set = lt_en && ft_en && (lt_idx == ft_idx);
  assign ft_base  = same_set ? tree_touch(st_q[ft_idx], lt_way) : st_q[ft_idx];
  assign victim   = tree_victim(st_q[ft_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      if (lt_en && !same_set) st_q[lt_idx] <= tree_touch(st_q[lt_idx], lt_way);
      if (ft_en)              st_q[ft_idx] <= tree_touch(ft_base, ft_way);
    end
  end
endmodule

// File: rtl/btic_ways.sv
module btic_ways
  import btic_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int TAG_W  = 26,
  parameter int INSN_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [TAG_W-1:0]    rd_tag,
  output logic [NUM_WAYS-1:0] rd_hit,
  output logic [INSN_W-1:0]   rd_i0,
  output logic [INSN_W-1:0]   rd_i1,
  output logic                rd_pair,
  input  logic [IDX_W-1:0]    pb_idx,
  input  logic [TAG_W-1:0]    pb_tag,
  output logic [NUM_WAYS-1:0] pb_hit,
  output logic [NUM_WAYS-1:0] pb_vld,
  input  logic                wr_en,
  input  way_t                wr_way,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [INSN_W-1:0]   wr_i0,
  input  logic [INSN_W-1:0]   wr_i1,
  input  logic                wr_pair
);
  logic [INSN_W-1:0] w_i0 [NUM_WAYS];
  logic [INSN_W-1:0] w_i1 [NUM_WAYS];
  logic [NUM_WAYS-1:0] w_pair;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   pair_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [INSN_W-1:0] i0_q  [SETS];
    logic [INSN_W-1:0] i1_q  [SETS];
    logic              sel;

    assign sel = wr_en && (wr_way == way_t'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= '0;
      else if (flush)  vld_q <= '0;
      else if (sel)    vld_q[pb_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[pb_idx]  <= wr_tag;
        i0_q[pb_idx]   <= wr_i0;
        i1_q[pb_idx]   <= wr_i1;
        pair_q[pb_idx] <= wr_pair;
      end
    end

    assign rd_hit[w] = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign pb_hit[w] = vld_q[pb_idx] && (tag_q[pb_idx] == pb_tag);
    assign pb_vld[w] = vld_q[pb_idx];
    assign w_i0[w]   = i0_q[rd_idx];
    assign w_i1[w]   = i1_q[rd_idx];
    assign w_pair[w] = pair_q[rd_idx];
  end

  always_comb begin
    rd_i0   = '0;
    rd_i1   = '0;
    rd_pair = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (rd_hit[w]) begin
        rd_i0   = rd_i0 | w_i0[w];
        rd_i1   = rd_i1 | w_i1[w];
        rd_pair = rd_pair | w_pair[w];
      end
    end
  end
endmodule

// File: rtl/btic_top.sv
module btic_top
  import btic_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int INSN_W    = 32,
  parameter int SETS      = 16,
  parameter int BLK_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_pair,
  output logic [INSN_W-1:0] rsp_insn0,
  output logic [INSN_W-1:0] rsp_insn1,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [INSN_W-1:0] fill_insn0,
  input  logic [INSN_W-1:0] fill_insn1
);
  localparam int IDX_W = $clog2(SETS);
  localparam int BW_W  = $clog2(BLK_WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic                lk_fire, fl_fire, fl_last;
  logic [NUM_WAYS-1:0] rd_hit, pb_hit, pb_vld;
  logic [INSN_W-1:0]   rd_i0, rd_i1;
  logic                rd_pair;
  way_t                victim, free_way, fill_way;
  logic                unused_lo;

  assign unused_lo  = ^{lk_addr[1:0], fill_addr[1:0]};
  assign lk_ready   = !flush;
  assign fill_ready = !flush;
  assign lk_fire    = lk_valid && lk_ready;
  assign fl_fire    = fill_valid && fill_ready;
  assign fl_last    = &fill_addr[2 +: BW_W];

  // resident address first, then lowest free way, then tree victim
  always_comb begin
    free_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!pb_vld[w]) free_way = way_t'(w);
  end

  always_comb begin
    if (|pb_hit)       fill_way = onehot_to_way(pb_hit);
    else if (!(&pb_vld)) fill_way = free_way;
    else               fill_way = victim;
  end

  btic_ways #(.SETS(SETS), .TAG_W(TAG_W), .INSN_W(INSN_W)) u_ways (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .rd_idx  (lk_addr[2 +: IDX_W]),
    .rd_tag  (lk_addr[ADDR_W-1 -: TAG_W]),
    .rd_hit  (rd_hit),
    .rd_i0   (rd_i0),
    .rd_i1   (rd_i1),
    .rd_pair (rd_pair),
    .pb_idx  (fill_addr[2 +: IDX_W]),
    .pb_tag  (fill_addr[ADDR_W-1 -: TAG_W]),
    .pb_hit  (pb_hit),
    .pb_vld  (pb_vld),
    .wr_en   (fl_fire),
    .wr_way  (fill_way),
    .wr_tag  (fill_addr[ADDR_W-1 -: TAG_W]),
    .wr_i0   (fill_insn0),
    .wr_i1   (fill_insn1),
    .wr_pair (!fl_last)
  );

  btic_plru #(.SETS(SETS)) u_plru (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .lt_en  (lk_fire && (|rd_hit)),
    .lt_idx (lk_addr[2 +: IDX_W]),
    .lt_way (onehot_to_way(rd_hit)),
    .ft_en  (fl_fire),
    .ft_idx (fill_addr[2 +: IDX_W]),
    .ft_way (fill_way),
    .victim (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pair  <= 1'b0;
      rsp_insn0 <= '0;
      rsp_insn1 <= '0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_hit   <= lk_fire && (|rd_hit);
      rsp_pair  <= lk_fire && (|rd_hit) && rd_pair;
      rsp_insn0 <= rd_i0;
      rsp_insn1 <= rd_i1;
    end
  end
endmodule

// File: rtl/btic_chk.sv
module btic_chk #(
  parameter int ADDR_W    = 32,
  parameter int BLK_WORDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              fill_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_pair
);
  localparam int BW_W = $clog2(BLK_WORDS);
  logic lk_last;
  logic unused_chk;
  assign lk_last    = &lk_addr[2 +: BW_W];
  assign unused_chk = ^{lk_addr[ADDR_W-1:2+BW_W], lk_addr[1:0]};

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !rsp_valid); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R2
  AST_PAIR_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pair |-> rsp_hit); // R3
  AST_LAST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_last) |=> !rsp_pair); // R9
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!lk_ready && !fill_ready)); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 (lk_valid && lk_ready) |=> !rsp_hit); // R10
endmodule

bind btic_top btic_chk #(.ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .lk_addr    (lk_addr),
  .fill_ready (fill_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_pair   (rsp_pair)
);

// File: tb/btic_top_tb.sv
`timescale 1ns/1ps
module btic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [31:0] fill_insn0 = '0;
  logic [31:0] fill_insn1 = '0;
  logic        lk_ready, fill_ready, rsp_valid, rsp_hit, rsp_pair;
  logic [31:0] rsp_insn0, rsp_insn1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btic_top u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pair(rsp_pair),
    .rsp_insn0(rsp_insn0), .rsp_insn1(rsp_insn1),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_insn0(fill_insn0), .fill_insn1(fill_insn1)
  );

  function automatic logic [31:0] mk(input int tag, input int set);
    return (32'(tag) << 6) | (32'(set) << 2);
  endfunction
  function automatic logic [31:0] d0(input logic [31:0] a, input int g);
    return (a * 32'd3) + 32'(g);
  endfunction
  function automatic logic [31:0] d1(input logic [31:0] a, input int g);
    return ~a ^ (32'(g) << 16);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input int g);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_insn0 = d0(a, g); fill_insn1 = d1(a, g);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // lookup, check response in the following cycle
  task automatic look(input logic [31:0] a, input bit exp_hit, input int g, input string req);
    bit exp_pair;
    exp_pair = (a[4:2] != 3'd7);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid === 1'b1, {req, " R2 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit === exp_hit, {req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) begin
      chk(rsp_insn0 === d0(a, g), {req, " R3 insn0"}, rsp_insn0, d0(a, g));
      if (exp_pair)
        chk(rsp_insn1 === d1(a, g), {req, " R3 insn1"}, rsp_insn1, d1(a, g));
      chk(rsp_pair === exp_pair, {req, " R9 pair"}, 32'(rsp_pair), 32'(exp_pair));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 idle rsp_valid", 32'(rsp_valid), 32'd0);
    chk(lk_ready === 1'b1 && fill_ready === 1'b1, "R1 ready", {30'd0, lk_ready, fill_ready}, 32'd3);
    for (int s = 0; s < 16; s++) look(mk(1, s), 1'b0, 0, "R1 empty");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 no request", 32'(rsp_valid), 32'd0);

    // R4 R5 fill all 64 entries, all stay resident; R9 via sets 7 and 15
    for (int s = 0; s < 16; s++)
      for (int t = 1; t <= 4; t++) fill(mk(t, s), 0);
    for (int s = 0; s < 16; s++)
      for (int t = 1; t <= 4; t++) look(mk(t, s), 1'b1, 0, "R4 R5 resident");
    for (int s = 0; s < 16; s++) look(mk(9, s), 1'b0, 0, "R4 absent tag");

    // R6 R7 replacement: tree now points to way 0 (tag 1) in every set
    for (int s = 0; s < 16; s++) begin
      if (s % 2 == 0) begin
        look(mk(1, s), 1'b1, 0, "R7 touch way0");
        fill(mk(5, s), 0);
        look(mk(3, s), 1'b0, 0, "R7 way2 evicted");
        look(mk(1, s), 1'b1, 0, "R7 way0 kept");
      end else begin
        fill(mk(5, s), 0);
        look(mk(1, s), 1'b0, 0, "R6 way0 evicted");
        look(mk(3, s), 1'b1, 0, "R6 way2 kept");
      end
      look(mk(5, s), 1'b1, 0, "R6 new entry");
    end

    // R10 flush
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(lk_ready === 1'b0 && fill_ready === 1'b0, "R10 ready low", {30'd0, lk_ready, fill_ready}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
    for (int s = 0; s < 16; s++) look(mk(5, s), 1'b0, 0, "R10 after flush");

    // R11 same-cycle lookup and fill
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(6, 2);
    fill_valid = 1'b1; fill_addr = mk(6, 2); fill_insn0 = d0(mk(6, 2), 0); fill_insn1 = d1(mk(6, 2), 0);
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b0, "R11 sees old state", {30'd0, rsp_valid, rsp_hit}, 32'd2);
    look(mk(6, 2), 1'b1, 0, "R11 filled");

    // R8 in-place refill in set 3
    fill(mk(1, 3), 0);
    fill(mk(2, 3), 0);
    fill(mk(3, 3), 0);
    fill(mk(1, 3), 7);
    fill(mk(4, 3), 0);
    look(mk(1, 3), 1'b1, 7, "R8 refreshed");
    look(mk(2, 3), 1'b1, 0, "R8 kept");
    look(mk(3, 3), 1'b1, 0, "R8 kept");
    look(mk(4, 3), 1'b1, 0, "R8 kept");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule